// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block holds the virtual-to-physical page mappings for data accesses. It has 64 entries, one per index, and uses 8 KB pages. A load/store unit presents a 32-bit virtual address with an enable. In the same cycle the block returns a hit flag, the 19-bit physical page number and four access-permission flags, all taken from the one entry that the address indexes. The block does not raise exceptions, check privilege or assemble the physical address. Its neighbour does that from these outputs.

Maintenance software owns the contents. A small register window exposes a match word (tag and valid) and a translate word (page number and permissions) for every entry. The software reads and writes those words by address. There is no refill hardware. After reset every entry is invalid, so all lookups miss until software writes entries in.

Top module: `dtlbTop`

## Requirements
- R1: After reset every entry's match and translate words read back as zero, and every lookup reports no hit.
- R2: A lookup indexes entry vaddr[18:13] and compares that entry's stored tag with vaddr[31:19]. Hit is high when the entry is valid, the tags are equal and lookupEn is high.
- R3: When lookupEn is low, hit is low whatever the stored contents are.
- R4: lookupPpn equals the indexed entry's translate bits 31:13. permUserWr, permUserRd, permSupWr and permSupRd equal its translate bits 9, 8, 7 and 6. All of these are combinational from vaddr, and vaddr[12:0] has no effect on them.
- R5: The register port is selected only when regSel is high, regAddr[10] is 1 and regAddr[8:6] is 000. When it is not selected, regRdata is zero and a write has no effect.
- R6: regAddr[9] picks the translate bank (1) or the match bank (0), and regAddr[5:0] picks the entry.
- R7: Match word layout: the tag is in bits 31:19 and the valid flag in bit 0. Written values keep only those bits, and every other bit reads back as zero.
- R8: Translate word layout: the physical page number is in bits 31:13 and the permissions are in bits 9:6. Written values keep only those bits, and bits 12:10 and 5:0 read back as zero.
- R9: A register write takes effect at the next rising clock edge. Before that edge, lookups and reads still see the old contents.
- R10: A write changes only the addressed word of the addressed entry. All other entries and the other bank keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookupEn | input | 1 | Translation enable for the lookup |
| vaddr | input | 32 | Virtual address to translate |
| hit | output | 1 | Indexed entry is valid and its tag matches |
| lookupPpn | output | 19 | Physical page number of the indexed entry |
| permUserWr | output | 1 | User write permitted |
| permUserRd | output | 1 | User read permitted |
| permSupWr | output | 1 | Supervisor write permitted |
| permSupRd | output | 1 | Supervisor read permitted |
| regSel | input | 1 | Register port chip-select |
| regWrite | input | 1 | Register port write strobe |
| regAddr | input | 11 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, zero when not selected |

## Verification
The bench mixes two kinds of lookup address. Some are built to reuse a written tag, and these separate a true hit from a tag mismatch at the same index. The others are fully random, and because entries are often invalid these exercise the miss path. Each lookup is repeated with enable low and with a different page offset, which shows that the enable gates the hit and that the offset bits do not change the outputs. Register accesses use random data with every bit set or cleared. Reading the words back shows that only the listed field bits are stored. Directed writes go outside the window, to a non-zero way and with the select off, and they show that a write is dropped when the port is not selected and that it lands only on the next edge.

// File: rtl/dtlbPkg.sv
package dtlbPkg;
  parameter int ENTRIES   = 64;
  parameter int IDX_W     = $clog2(ENTRIES);
  parameter int WORD_W    = 32;
  parameter int PAGE_BITS = 13;
  parameter int REG_AW    = 11;
  localparam int PPN_W    = WORD_W - PAGE_BITS;
  localparam int TAG_LSB  = PAGE_BITS + IDX_W;
  localparam int TAG_W    = WORD_W - TAG_LSB;
  localparam int PERM_LSB = 6;
  localparam int WIN_BIT  = 10;
  localparam int BANK_BIT = 9;

  // bits kept by the two register words
  localparam logic [WORD_W-1:0] MATCH_MASK =
    {{TAG_W{1'b1}}, {(WORD_W-TAG_W-1){1'b0}}, 1'b1};
  localparam logic [WORD_W-1:0] TRANS_MASK =
    {{PPN_W{1'b1}}, {(PAGE_BITS-PERM_LSB-4){1'b0}}, 4'hF, {PERM_LSB{1'b0}}};

  typedef struct packed {
    logic             sel;
    logic             bankTrans;
    logic             wrMatch;
    logic             wrTrans;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/dtlbRegCtl.sv
module dtlbRegCtl
  import dtlbPkg::*;
(
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strobe
);
  logic inWindow;
  logic wayZero;

  assign inWindow = regAddr[WIN_BIT];
  assign wayZero  = (regAddr[BANK_BIT-1:IDX_W] == '0);

  always_comb begin
    strobe           = '0;
    strobe.sel       = regSel & inWindow & wayZero;
    strobe.bankTrans = regAddr[BANK_BIT];
    strobe.idx       = regAddr[IDX_W-1:0];
    strobe.wrMatch   = strobe.sel & regWrite & ~regAddr[BANK_BIT];
    strobe.wrTrans   = strobe.sel & regWrite & regAddr[BANK_BIT];
  end
endmodule

// File: rtl/dtlbStore.sv
module dtlbStore
  import dtlbPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupEn,
  input  logic [WORD_W-1:0] vaddr,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] wdata,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn,
  output logic [3:0]        perm,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] matchWord [ENTRIES];
  logic [WORD_W-1:0] transWord [ENTRIES];

  // one register pair per entry, masked so only implemented bits hold state
  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (rst) begin
        matchWord[e] <= '0;
        transWord[e] <= '0;
      end else begin
        if (strobe.wrMatch && strobe.idx == IDX_W'(e))
          matchWord[e] <= wdata & MATCH_MASK;
        if (strobe.wrTrans && strobe.idx == IDX_W'(e))
          transWord[e] <= wdata & TRANS_MASK;
      end
    end
  end

  logic [IDX_W-1:0]  lkIdx;
  logic [TAG_W-1:0]  lkTag;
  logic [WORD_W-1:0] lkMatch;
  logic [WORD_W-1:0] lkTrans;

  assign lkIdx   = vaddr[TAG_LSB-1:PAGE_BITS];
  assign lkTag   = vaddr[WORD_W-1:TAG_LSB];
  assign lkMatch = matchWord[lkIdx];
  assign lkTrans = transWord[lkIdx];

  assign hit  = lookupEn & lkMatch[0] & (lkMatch[WORD_W-1:TAG_LSB] == lkTag);
  assign ppn  = lkTrans[WORD_W-1:PAGE_BITS];
  assign perm = lkTrans[PERM_LSB+3:PERM_LSB];

  always_comb begin
    rdata = '0;
    if (strobe.sel)
      rdata = strobe.bankTrans ? transWord[strobe.idx] : matchWord[strobe.idx];
  end

  AST_WR_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.wrMatch, strobe.wrTrans})) else $error("two banks written"); // R6
  AST_UNSEL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !strobe.sel |-> rdata == '0) else $error("read data leaked"); // R5
  AST_MATCH_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.sel && !strobe.bankTrans) |-> rdata[WORD_W-TAG_W-1:1] == '0)
    else $error("match pad bits set"); // R7
  AST_TRANS_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe.sel && strobe.bankTrans) |->
      (rdata[PAGE_BITS-1:PERM_LSB+4] == '0 && rdata[PERM_LSB-1:0] == '0))
    else $error("translate pad bits set"); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (strobe.wrMatch && strobe.idx == lkIdx) |=>
      ($past(lkIdx) != lkIdx || lkMatch == ($past(wdata) & MATCH_MASK)))
    else $error("match write lost"); // R9
endmodule

// File: rtl/dtlbTop.sv
module dtlbTop
  import dtlbPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lookupEn,
  input  logic [WORD_W-1:0] vaddr,
  output logic              hit,
  output logic [PPN_W-1:0]  lookupPpn,
  output logic              permUserWr,
  output logic              permUserRd,
  output logic              permSupWr,
  output logic              permSupRd,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata
);
  regStrobe_t strobe;
  logic [3:0] perm;

  dtlbRegCtl u_ctl (
    .regSel  (regSel),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  dtlbStore u_store (
    .clk     (clk),
    .rst     (rst),
    .lookupEn(lookupEn),
    .vaddr   (vaddr),
    .strobe  (strobe),
    .wdata   (regWdata),
    .hit     (hit),
    .ppn     (lookupPpn),
    .perm    (perm),
    .rdata   (regRdata)
  );

  assign permUserWr = perm[3];
  assign permUserRd = perm[2];
  assign permSupWr  = perm[1];
  assign permSupRd  = perm[0];

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    hit |-> lookupEn) else $error("hit while disabled"); // R3
  AST_NO_HIT_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !hit) else $error("hit right after reset"); // R1
endmodule

// File: tb/dtlbTop_bench.sv
module dtlbTop_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookupEn = 1'b0;
  logic [31:0] vaddr = '0;
  logic        hit;
  logic [18:0] lookupPpn;
  logic        permUserWr, permUserRd, permSupWr, permSupRd;
  logic        regSel = 1'b0;
  logic        regWrite = 1'b0;
  logic [10:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mMatch [64];
  logic [31:0] mTrans [64];

  localparam logic [31:0] M_MASK = 32'hFFF8_0001;
  localparam logic [31:0] T_MASK = 32'hFFFF_E3C0;
  localparam logic [10:0] M_BASE = 11'h400;
  localparam logic [10:0] T_BASE = 11'h600;

  dtlbTop u_dtlbTop (
    .clk(clk), .rst(rst), .lookupEn(lookupEn), .vaddr(vaddr), .hit(hit),
    .lookupPpn(lookupPpn), .permUserWr(permUserWr), .permUserRd(permUserRd),
    .permSupWr(permSupWr), .permSupRd(permSupRd), .regSel(regSel),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expHit(input logic en, input logic [31:0] va);
    logic [31:0] m;
    m = mMatch[va[18:13]];
    return en & m[0] & (m[31:19] == va[31:19]);
  endfunction

  function automatic logic [22:0] expTrans(input logic [31:0] va);
    logic [31:0] t;
    t = mTrans[va[18:13]];
    return {t[31:13], t[9:6]};
  endfunction

  task automatic doLookup(input logic en, input logic [31:0] va, input string req);
    @(negedge clk);
    lookupEn = en; vaddr = va;
    #1;
    chk(req, {31'd0, hit}, {31'd0, expHit(en, va)});
    chk(req, {9'd0, lookupPpn, permUserWr, permUserRd, permSupWr, permSupRd},
        {9'd0, expTrans(va)});
  endtask

  task automatic regWr(input logic sel, input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1;
    regSel = 1'b0; regWrite = 1'b0;
    if (sel && a[10] && a[8:6] == 3'b0) begin
      if (a[9]) mTrans[a[5:0]] = d & T_MASK;
      else      mMatch[a[5:0]] = d & M_MASK;
    end
  endtask

  task automatic regRd(input logic sel, input logic [10:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    regSel = sel; regWrite = 1'b0; regAddr = a;
    #1;
    e = '0;
    if (sel && a[10] && a[8:6] == 3'b0) e = a[9] ? mTrans[a[5:0]] : mMatch[a[5:0]];
    chk(req, regRdata, e);
    regSel = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] va;
    logic [5:0]  ix;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) begin mMatch[i] = '0; mTrans[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 64; i += 9) begin
      regRd(1'b1, M_BASE | 11'(i), "R1 match after reset");
      regRd(1'b1, T_BASE | 11'(i), "R1 translate after reset");
    end
    doLookup(1'b1, 32'hFFFF_FFFF, "R1 lookup after reset");

    // R7/R8: all-ones data keeps only field bits; R6 bank separation
    regWr(1'b1, M_BASE | 11'd5, 32'hFFFF_FFFF);
    regRd(1'b1, M_BASE | 11'd5, "R7 match layout");
    regRd(1'b1, T_BASE | 11'd5, "R10 other bank untouched");
    regWr(1'b1, T_BASE | 11'd5, 32'hFFFF_FFFF);
    regRd(1'b1, T_BASE | 11'd5, "R8 translate layout");
    regRd(1'b1, M_BASE | 11'd6, "R10 neighbour entry untouched");

    // R2/R3/R4: hit, miss by tag, enable off, offset bits irrelevant
    va = {13'h1FFF, 6'd5, 13'h0ABC};
    doLookup(1'b1, va, "R2 hit on programmed entry");
    doLookup(1'b1, va ^ 32'h8000_0000, "R2 tag mismatch");
    doLookup(1'b0, va, "R3 enable low");
    doLookup(1'b1, {va[31:13], 13'h1555}, "R4 offset ignored");

    // R5: writes outside the window, to way 1, or with select off
    regWr(1'b1, 11'h000 | 11'd5, 32'h0);
    regWr(1'b1, M_BASE | 11'h040 | 11'd5, 32'h0);
    regWr(1'b0, M_BASE | 11'd5, 32'h0);
    regRd(1'b1, M_BASE | 11'd5, "R5 ignored writes left match");
    regRd(1'b1, M_BASE | 11'h040 | 11'd5, "R5 way1 reads zero");
    regRd(1'b0, T_BASE | 11'd5, "R5 unselected read zero");

    // R9: write lands only at the next edge
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = M_BASE | 11'd5; regWdata = 32'h0;
    lookupEn = 1'b1; vaddr = va;
    #1;
    chk("R9 old value before edge", {31'd0, hit}, 32'd1);
    @(posedge clk);
    #1;
    regSel = 1'b0; regWrite = 1'b0;
    mMatch[5] = 32'h0;
    chk("R9 new value after edge", {31'd0, hit}, 32'd0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      ix = 6'($urandom_range(0, 63));
      d  = $urandom;
      case ($urandom_range(0, 4))
        0: regWr(1'b1, M_BASE | 11'(ix), d | 32'h1);
        1: regWr(1'b1, T_BASE | 11'(ix), d);
        2: regRd(1'b1, ($urandom_range(0, 1) ? T_BASE : M_BASE) | 11'(ix), "R6 random read");
        3: doLookup(1'($urandom_range(0, 1)), {mMatch[ix][31:19], ix, d[12:0]}, "R2 random near-hit");
        default: doLookup(1'b1, d, "R4 random lookup");
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule